// File: doc/BRIEF.md
# TLB Invalidation Controller

This block removes stale translations from a small translation lookaside buffer. Software picks the streams to invalidate and then issues a command through a 32-bit register port. The controller then visits every buffer entry, one entry per clock. Each valid entry whose stream tag is in the selection is cleared through a tag-clear port. While this walk is running, a busy flag reads back as 1, so software can poll the command register until the flag returns to 0.

A build parameter picks one of two command styles:

- **Mask style.** Software writes a per-stream selection mask. It then writes a command word with a trigger bit set.
- **Opcode style.** A single command word carries an operation code and a stream number. The code selects flush-all or flush-one-stream.

Both styles use the same walk and the same busy behaviour. Only the registers of the selected style respond. The buffer storage sits outside the block. The controller presents an entry index, and the storage returns that entry's valid bit and stream tag in the same cycle.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset, busy is 0, the mask register reads 0 and no clear is issued.
- R2: In mask style, offset 0x34 holds a selection mask of NUM_STREAMS bits, where bit n selects stream n. It reads back the value written, with the upper bits read as 0.
- R3: In mask style, a write to offset 0x20 with bit 20 set starts a flush of the streams set in the mask. Bit 2 of offset 0x20 reads 1 while the flush runs.
- R4: In opcode style, a write to offset 0x80 acts on the code in bits [9:8]. Code 0 flushes all streams, and code 1 flushes only the stream numbered in bits [3:0]. Codes 2 and 3 have no effect.
- R5: In opcode style, bit 31 of offset 0x80 reads 1 while a flush runs.
- R6: A flush visits entries 0 to NUM_ENTRIES-1 at one entry per clock. Busy is 1 for exactly NUM_ENTRIES cycles. The flush clears every valid entry whose tag is selected and no other entry.
- R7: A command written while busy is 1 is ignored. The running walk is neither restarted nor re-targeted, and it finishes on its original schedule.
- R8: A flush with an empty selection never raises busy and clears nothing.
- R9: Registers of the style not selected, and all unmapped offsets, read as 0.
- R10: In mask style, a write to offset 0x20 with bit 20 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 12 | Read byte offset |
| reg_rdata | output | 32 | Read data (combinational) |
| walk_idx | output | $clog2(NUM_ENTRIES) | Entry being inspected |
| entry_valid | input | 1 | Valid bit of entry walk_idx |
| entry_tag | input | $clog2(NUM_STREAMS) | Stream tag of entry walk_idx |
| clr_en | output | 1 | Clear the valid bit of entry clr_idx |
| clr_idx | output | $clog2(NUM_ENTRIES) | Entry to clear |
| busy | output | 1 | Walk in progress |

## Verification
The hardest case to reach is a second command that lands in the middle of a walk. That command carries a different selection, and in mask style the mask register is rewritten as well. The stimulus starts a single-stream flush and waits a fixed number of cycles. It then issues a flush-all, and in mask style it also rewrites the mask. The bench then confirms two things. First, the busy count continues from where it was instead of restarting. Second, only the originally selected stream lost its entries. Every single-stream selection is swept in both styles against buffer contents generated arithmetically, so each tag appears both as a hit and as a miss.

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl #(
  parameter int NUM_STREAMS = 16,
  parameter int NUM_ENTRIES = 16,
  parameter bit OPCODE_MODE = 1'b0,
  localparam int SW = $clog2(NUM_STREAMS),
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [11:0]   reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [11:0]   reg_raddr,
  output logic [31:0]   reg_rdata,
  output logic [IW-1:0] walk_idx,
  input  logic          entry_valid,
  input  logic [SW-1:0] entry_tag,
  output logic          clr_en,
  output logic [IW-1:0] clr_idx,
  output logic          busy
);
  localparam logic [11:0] MASK_CMD = 12'h020;
  localparam logic [11:0] MASK_SEL = 12'h034;
  localparam logic [11:0] OP_CMD   = 12'h080;
  localparam logic [IW-1:0] LAST   = IW'(NUM_ENTRIES - 1);
  localparam logic [NUM_STREAMS-1:0] ALL = '1;

  logic [NUM_STREAMS-1:0] mask_q, sel_q, new_sel;
  logic [IW-1:0] idx_q;
  logic busy_q, cmd_hit, start;

  always_comb begin
    if (OPCODE_MODE) begin
      cmd_hit = reg_wr && reg_waddr == OP_CMD && !reg_wdata[9];
      new_sel = reg_wdata[8] ? (NUM_STREAMS'(1) << reg_wdata[SW-1:0]) : ALL;
    end else begin
      cmd_hit = reg_wr && reg_waddr == MASK_CMD && reg_wdata[20];
      new_sel = mask_q;
    end
  end

  assign start = cmd_hit && !busy_q && (|new_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (!OPCODE_MODE && reg_wr && reg_waddr == MASK_SEL)
        mask_q <= reg_wdata[NUM_STREAMS-1:0];
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        sel_q  <= new_sel;
      end else if (busy_q) begin
        if (idx_q == LAST) busy_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign walk_idx = idx_q;
  assign clr_idx  = idx_q;
  assign clr_en   = busy_q && entry_valid && sel_q[entry_tag];

  always_comb begin
    reg_rdata = '0;
    if (OPCODE_MODE) begin
      if (reg_raddr == OP_CMD) reg_rdata[31] = busy_q;
    end else begin
      if (reg_raddr == MASK_CMD) reg_rdata[2] = busy_q;
      if (reg_raddr == MASK_SEL) reg_rdata[NUM_STREAMS-1:0] = mask_q;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !clr_en);
  p_walk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && walk_idx != LAST |=> busy && walk_idx == $past(walk_idx) + 1'b1);
  p_walk_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && walk_idx == LAST |=> !busy);
  p_walk_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> walk_idx == '0);
  p_clear_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> busy && entry_valid);
  p_sel_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(sel_q));
  p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_hit && new_sel == '0 |=> !busy);
endmodule

// File: tb/sim_tlb_inval_ctrl.sv
module sim_tlb_inval_ctrl;
  localparam int NS = 16, NE = 16;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic wr0 = 0, wr1 = 0;
  logic [11:0] waddr = 0, raddr = 0;
  logic [31:0] wdata = 0, rd0, rd1;
  logic [3:0] widx0, widx1, cidx0, cidx1;
  logic clr0, clr1, busy0, busy1;
  logic [NE-1:0] v0, v1, ldv0 = 0, ldv1 = 0;
  logic ld0 = 0, ld1 = 0;
  logic [3:0] t0 [NE];
  logic [3:0] t1 [NE];
  int errors = 0, checks = 0;
  bit done = 0;

  tlb_inval_ctrl #(.NUM_STREAMS(NS), .NUM_ENTRIES(NE), .OPCODE_MODE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr0), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_raddr(raddr), .reg_rdata(rd0), .walk_idx(widx0), .entry_valid(v0[widx0]),
    .entry_tag(t0[widx0]), .clr_en(clr0), .clr_idx(cidx0), .busy(busy0));
  tlb_inval_ctrl #(.NUM_STREAMS(NS), .NUM_ENTRIES(NE), .OPCODE_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_raddr(raddr), .reg_rdata(rd1), .walk_idx(widx1), .entry_valid(v1[widx1]),
    .entry_tag(t1[widx1]), .clr_en(clr1), .clr_idx(cidx1), .busy(busy1));

  always_ff @(posedge clk) begin
    if (ld0) v0 <= ldv0; else if (clr0) v0[cidx0] <= 1'b0;
    if (ld1) v1 <= ldv1; else if (clr1) v1[cidx1] <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [NE-1:0] pat_v(input int seed);
    for (int i = 0; i < NE; i++) pat_v[i] = ((i * 7 + seed) % 3) != 0;
  endfunction

  function automatic logic [3:0] pat_t(input int i, input int seed);
    return 4'((i * 5 + seed) % NS);
  endfunction

  function automatic logic [NE-1:0] expect_v(input int seed, input logic [NS-1:0] sel);
    logic [NE-1:0] v = pat_v(seed);
    for (int i = 0; i < NE; i++) if (sel[pat_t(i, seed)]) v[i] = 1'b0;
    return v;
  endfunction

  task automatic load(input bit inst, input int seed);
    @(negedge clk);
    for (int i = 0; i < NE; i++) begin
      if (inst) t1[i] = pat_t(i, seed); else t0[i] = pat_t(i, seed);
    end
    if (inst) begin ldv1 = pat_v(seed); ld1 = 1; end
    else begin ldv0 = pat_v(seed); ld0 = 1; end
    @(negedge clk);
    ld0 = 0; ld1 = 0;
  endtask

  task automatic wr(input bit inst, input logic [11:0] a, input logic [31:0] d);
    waddr = a; wdata = d;
    if (inst) wr1 = 1; else wr0 = 1;
    @(negedge clk);
    wr0 = 0; wr1 = 0;
  endtask

  task automatic poll(input bit inst, output int cnt);
    cnt = 0;
    raddr = inst ? 12'h080 : 12'h020;
    #1;
    while ((inst ? rd1[31] : rd0[2]) && cnt < 100) begin
      cnt++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_mask(input logic [NS-1:0] m, input int seed);
    int cnt;
    load(0, seed);
    wr(0, 12'h034, 32'(m));
    wr(0, 12'h020, 32'h0010_0000);
    poll(0, cnt);
    check(cnt == (m == 0 ? 0 : NE), m == 0 ? "R8 empty busy" : "R3 R6 busy cycles", cnt, m == 0 ? 0 : NE);
    check(v0 == expect_v(seed, m), m == 0 ? "R8 nothing cleared" : "R6 mask flush result", v0, expect_v(seed, m));
  endtask

  task automatic run_op(input bit one, input int sid, input int seed);
    int cnt;
    logic [NS-1:0] sel;
    sel = one ? NS'(1) << sid : '1;
    load(1, seed);
    wr(1, 12'h080, one ? (32'h100 | 32'(sid)) : 32'h0);
    poll(1, cnt);
    check(cnt == NE, "R5 R6 busy cycles", cnt, NE);
    check(v1 == expect_v(seed, sel), "R4 opcode flush result", v1, expect_v(seed, sel));
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    raddr = 12'h034; #1;
    check(!busy0 && !busy1 && !clr0 && !clr1, "R1 reset idle", {busy0, busy1, clr0, clr1}, 0);
    check(rd0 == 0, "R1 mask reset", rd0, 0);
    rst_n = 1;
    @(negedge clk);
    wr(0, 12'h034, 32'hFFFF_FFFF);
    raddr = 12'h034; #1;
    check(rd0 == 32'h0000_FFFF, "R2 mask readback", rd0, 32'hFFFF);
    wr(0, 12'h034, 32'h0000_5A3C);
    raddr = 12'h034; #1;
    check(rd0 == 32'h5A3C, "R2 mask readback", rd0, 32'h5A3C);
    raddr = 12'h080; #1;
    check(rd0 == 0, "R9 opcode reg absent in mask style", rd0, 0);
    raddr = 12'h034; #1;
    check(rd1 == 0, "R9 mask reg absent in opcode style", rd1, 0);
    raddr = 12'h020; #1;
    check(rd1 == 0, "R9 mask cmd absent in opcode style", rd1, 0);
    raddr = 12'h044; #1;
    check(rd0 == 0 && rd1 == 0, "R9 unmapped offset", {rd0, rd1}, 0);

    for (int s = 0; s < NS; s++) run_mask(NS'(1) << s, s);
    run_mask(16'hFFFF, 3);
    run_mask(16'hA5A5, 4);
    run_mask(16'h0003, 5);
    run_mask(16'h0000, 6);

    load(0, 7);
    wr(0, 12'h034, 32'hFFFF);
    wr(0, 12'h020, 32'h000F_FFFF);
    poll(0, cnt);
    check(cnt == 0 && v0 == pat_v(7), "R10 no trigger bit", {cnt, v0}, {32'd0, pat_v(7)});

    for (int s = 0; s < NS; s++) run_op(1, s, s + 1);
    run_op(0, 0, 9);
    run_op(0, 0, 10);

    for (int c = 2; c < 4; c++) begin
      load(1, 11);
      wr(1, 12'h080, 32'(c << 8) | 32'h5);
      poll(1, cnt);
      check(cnt == 0 && v1 == pat_v(11), "R4 reserved code ignored", {cnt, v1}, {32'd0, pat_v(11)});
    end

    load(1, 12);
    wr(1, 12'h080, 32'h103);
    repeat (4) @(negedge clk);
    wr(1, 12'h080, 32'h0);
    poll(1, cnt);
    check(cnt == NE - 5, "R7 opcode walk not restarted", cnt, NE - 5);
    check(v1 == expect_v(12, 16'h0008), "R7 opcode walk not retargeted", v1, expect_v(12, 16'h0008));

    load(0, 13);
    wr(0, 12'h034, 32'h0002);
    wr(0, 12'h020, 32'h0010_0000);
    repeat (4) @(negedge clk);
    wr(0, 12'h034, 32'hFFFF);
    wr(0, 12'h020, 32'h0010_0000);
    poll(0, cnt);
    check(cnt == NE - 6, "R7 mask walk not restarted", cnt, NE - 6);
    check(v0 == expect_v(13, 16'h0002), "R7 mask walk not retargeted", v0, expect_v(13, 16'h0002));

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule